// File: doc/BRIEF.md
# Two-Channel Integrator Sequencer

This block is the digital control for an optical sensor cell that holds two integrating pixels. A serial token enters on `ser_in` and moves through three stages that capture on the rising clock edge. The stage values are decoded into four switch controls:

- a read-out select for pixel A and for pixel B;
- an integrator clear for pixel A and for pixel B.

The decode also gives an enable that marks when the shared analog output is driven. When the enable is low, that output is meant to float.

A fourth stage updates on the falling clock edge and copies the second stage to `ser_out`. Cells can therefore be chained on one clock. A downstream cell picks up the token on the rising edge that opens the third cycle of the upstream cell.

A single token produces a fixed four-cycle pattern:

1. Pixel A is read.
2. Pixel B is read while pixel A is cleared.
3. Pixel B is cleared and pixel A starts integrating again.
4. Every control is idle and pixel B integrates again.

A second token sets the end of the integration window. Every register clears under a synchronous active-low reset.

Top module: `pixel_pair_sequencer`

## Requirements
- R1: A high bit on `ser_in` sampled at a rising edge makes `pick_a` high for the following clock period, provided the second stage (`clear_a`) is low in that period. Clears are not raised by the first stage alone.
- R2: In the period after `pick_a` was high, `pick_b` and `clear_a` are high and `pick_a` is low, unless a new bit was captured in the meantime.
- R3: In the third period after a token enters, `clear_b` is high, while `pick_b` and `clear_a` drop unless the token was followed by another high bit.
- R4: In the fourth period after an isolated token, all four controls and `ana_en` are low.
- R5: `ser_out` follows the second stage with a half-period delay. It rises at the falling edge inside the second period, and it stays high for exactly one clock period.
- R6: `ana_en` is high exactly when one of `pick_a` and `pick_b` is high.
- R7: `pick_a` and `pick_b` are never high together. While `pick_b` is high, a newly captured bit does not raise `pick_a`.
- R8: While `rst_n` is low at a clock edge, all stages clear, and the controls and `ser_out` read low regardless of `ser_in`.
- R9: Every control output holds its value for a full clock period. It changes only at the rising edge and is unchanged across the falling edge.
- R10: A second cell whose `ser_in` is fed from `ser_out` raises its `pick_a` two periods after the first cell did.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cell_clk | input | 1 | Sequencer clock; stages capture on the rising edge, chain output on the falling edge |
| rst_n | input | 1 | Synchronous active-low reset of all stages |
| ser_in | input | 1 | Serial token input |
| ser_out | output | 1 | Serial token output to the next cell |
| pick_a | output | 1 | Read-out select, pixel A |
| pick_b | output | 1 | Read-out select, pixel B |
| clear_a | output | 1 | Integrator clear, pixel A |
| clear_b | output | 1 | Integrator clear, pixel B |
| ana_en | output | 1 | Analog output driven (high) or floating (low) |

## Verification
Isolated single tokens show the basic four-period pattern and the half-period lag of `ser_out`. Tokens spaced four periods apart show that back-to-back windows do not disturb each other. Tokens spaced two periods apart and adjacent high bits overlap the stages, so they separate a correct select-exclusion decode from one that lets both selects rise together. A long high run holds every stage high at once. A reset asserted mid-token with `ser_in` held high shows that reset dominates. A second chained cell confirms the capture edge for the downstream token.

// File: rtl/pixel_seq_pkg.sv
// Package: shared types and constants for the two-pixel sequencer.
// Assumes the sequencer uses at least three rising-edge stages.
package pixel_seq_pkg;

    // Minimum rising-edge stage count needed by the decode.
    localparam int unsigned MIN_RISE_STAGES = 3;

    // Decoded switch controls for one cell.
    typedef struct packed {
        logic pick_a;
        logic pick_b;
        logic clear_a;
        logic clear_b;
        logic ana_en;
    } seq_ctrl_t;

endpackage

// File: rtl/pixel_seq_rise_chain.sv
// Module: rising-edge shift chain that moves the serial token one stage per clock.
// Assumes DEPTH >= 2; the synchronous active-low reset clears every stage.
module pixel_seq_rise_chain #(
    parameter int unsigned DEPTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_in,
    output logic [DEPTH-1:0] stages
);

    // Shift the token one place per rising edge; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stages <= '0;
        end else begin
            stages <= {stages[DEPTH-2:0], shift_in};
        end
    end

endmodule

// File: rtl/pixel_seq_fall_stage.sv
// Module: single falling-edge register that forms the chain output.
// Assumes the reset is sampled at the falling edge like the data.
module pixel_seq_fall_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    // Capture the tapped stage half a period after it changes.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/pixel_seq_decode.sv
// Module: combinational decode of stage values into select and clear controls.
// Assumes stage 0 is the newest token position; stage 1 and stage 2 follow.
module pixel_seq_decode
    import pixel_seq_pkg::*;
#(
    parameter int unsigned DEPTH = 3
) (
    input  logic [DEPTH-1:0] stages,
    output seq_ctrl_t        ctrl
);

    // Map stage positions to the four switches and the output enable.
    always_comb begin
        ctrl.pick_a  = stages[0] & ~stages[1];
        ctrl.pick_b  = stages[1];
        ctrl.clear_a = stages[1];
        ctrl.clear_b = stages[2];
        ctrl.ana_en  = ctrl.pick_a | ctrl.pick_b;
    end

endmodule

// File: rtl/pixel_pair_sequencer.sv
// Module: top of the two-pixel integrator sequencer with chain output.
// Assumes one clock drives both edges and the reset is synchronous, active low.
module pixel_pair_sequencer
    import pixel_seq_pkg::*;
#(
    parameter int unsigned RISE_STAGES = 3
) (
    input  logic cell_clk,
    input  logic rst_n,
    input  logic ser_in,
    output logic ser_out,
    output logic pick_a,
    output logic pick_b,
    output logic clear_a,
    output logic clear_b,
    output logic ana_en
);

    // Index of the stage that feeds the chain output.
    localparam int unsigned CHAIN_TAP = 1;

    logic [RISE_STAGES-1:0] stage_q;
    seq_ctrl_t              ctrl;

    // Reject a stage count the decode cannot use.
    generate
        if (RISE_STAGES < MIN_RISE_STAGES) begin : g_bad_depth
            initial $error("RISE_STAGES must be at least %0d", MIN_RISE_STAGES);
        end
    endgenerate

    pixel_seq_rise_chain #(.DEPTH(RISE_STAGES)) u_chain (
        .clk      (cell_clk),
        .rst_n    (rst_n),
        .shift_in (ser_in),
        .stages   (stage_q)
    );

    pixel_seq_fall_stage u_out (
        .clk   (cell_clk),
        .rst_n (rst_n),
        .d     (stage_q[CHAIN_TAP]),
        .q     (ser_out)
    );

    pixel_seq_decode #(.DEPTH(RISE_STAGES)) u_dec (
        .stages (stage_q),
        .ctrl   (ctrl)
    );

    // Drive the ports from the decoded controls.
    always_comb begin
        pick_a  = ctrl.pick_a;
        pick_b  = ctrl.pick_b;
        clear_a = ctrl.clear_a;
        clear_b = ctrl.clear_b;
        ana_en  = ctrl.ana_en;
    end

endmodule

// File: rtl/pixel_pair_sequencer_chk.sv
// Checker: temporal properties of the sequencer, bound to its top module.
// Assumes the bench applies reset at least once before relying on the outputs.
module pixel_pair_sequencer_chk (
    input logic cell_clk,
    input logic rst_n,
    input logic ser_in,
    input logic ser_out,
    input logic pick_a,
    input logic pick_b,
    input logic clear_a,
    input logic clear_b,
    input logic ana_en
);

    logic armed = 1'b0;

    // Note that a reset edge has been seen.
    always_ff @(posedge cell_clk) begin
        if (!rst_n) begin
            armed <= 1'b1;
        end
    end

    // R1: a captured high bit raises one of the selects next period.
    a_r1_capture: assert property (@(posedge cell_clk) disable iff (!rst_n || !armed)
        ser_in |=> (pick_a || pick_b));

    // R2: pixel A read hands over to pixel B read with pixel A clear.
    a_r2_handoff: assert property (@(posedge cell_clk) disable iff (!rst_n || !armed)
        pick_a |=> (pick_b && clear_a && !pick_a));

    // R3: pixel B read is followed by pixel B clear.
    a_r3_clear_b: assert property (@(posedge cell_clk) disable iff (!rst_n || !armed)
        pick_b |=> clear_b);

    // R5: the chain output tracks the second stage across the falling edge.
    a_r5_chain_lag: assert property (@(posedge cell_clk) disable iff (!rst_n || !armed)
        ser_out == clear_a);

    // R6: the output enable marks exactly one active select.
    a_r6_enable: assert property (@(posedge cell_clk) disable iff (!rst_n || !armed)
        ana_en == ($countones({pick_a, pick_b}) == 1));

    // R7: the two selects never overlap.
    a_r7_exclusive: assert property (@(posedge cell_clk) disable iff (!rst_n || !armed)
        $onehot0({pick_a, pick_b}));

    // R8: a reset edge leaves every control low.
    a_r8_reset_clear: assert property (@(posedge cell_clk)
        (armed && !rst_n) |=> (!pick_a && !pick_b && !clear_a && !clear_b && !ana_en));

endmodule

bind pixel_pair_sequencer pixel_pair_sequencer_chk u_chk (.*);

// File: tb/pixel_pair_sequencer_bench.sv
// Bench: scoreboard for two chained sequencer cells.
// The driver pushes expected controls per period; the monitor compares them.
module pixel_pair_sequencer_bench;

    typedef struct {
        logic pa, pb, ca, cb, en, so, nxt_pa;
    } exp_t;

    logic cell_clk = 1'b0;
    logic rst_n    = 1'b0;
    logic ser_in   = 1'b0;
    logic ser_out, pick_a, pick_b, clear_a, clear_b, ana_en;
    logic n_out, n_pa, n_pb, n_ca, n_cb, n_en;

    exp_t exp_q[$];
    int   vectors = 0;
    int   fails   = 0;
    logic h1 = 1'b0, h2 = 1'b0, h3 = 1'b0;
    bit   finished = 1'b0;

    always #4 cell_clk = ~cell_clk;

    pixel_pair_sequencer u_pixel_pair_sequencer (
        .cell_clk (cell_clk), .rst_n (rst_n), .ser_in (ser_in), .ser_out (ser_out),
        .pick_a (pick_a), .pick_b (pick_b), .clear_a (clear_a), .clear_b (clear_b),
        .ana_en (ana_en)
    );

    pixel_pair_sequencer u_next (
        .cell_clk (cell_clk), .rst_n (rst_n), .ser_in (ser_out), .ser_out (n_out),
        .pick_a (n_pa), .pick_b (n_pb), .clear_a (n_ca), .clear_b (n_cb),
        .ana_en (n_en)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // Called at posedge+2: set the bit, then queue the expectation after the edge.
    task automatic drive_bit(input logic b);
        exp_t e;
        ser_in = b;
        @(posedge cell_clk);
        e.pa     = b & ~h1;
        e.pb     = h1;
        e.ca     = h1;
        e.cb     = h2;
        e.en     = e.pa | e.pb;
        e.so     = h1;
        e.nxt_pa = h2 & ~h3;
        exp_q.push_back(e);
        h3 = h2; h2 = h1; h1 = b;
        #2;
    endtask

    task automatic drive_pattern(input logic [31:0] bits, input int n);
        for (int i = n - 1; i >= 0; i--) drive_bit(bits[i]);
    endtask

    // R8: reset with ser_in high; outputs stay low.
    task automatic do_reset();
        rst_n  = 1'b0;
        ser_in = 1'b1;
        for (int k = 0; k < 2; k++) begin
            @(posedge cell_clk); #3;
            chk("R8 pick_a", pick_a, 1'b0);
            chk("R8 pick_b", pick_b, 1'b0);
            chk("R8 clear_a", clear_a, 1'b0);
            chk("R8 clear_b", clear_b, 1'b0);
            chk("R8 ana_en", ana_en, 1'b0);
            #3;
            chk("R8 ser_out", ser_out, 1'b0);
        end
        @(posedge cell_clk); #2;
        rst_n = 1'b1;
        h1 = 1'b0; h2 = 1'b0; h3 = 1'b0;
    endtask

    // Monitor: pop one expectation per period and compare at both half-periods.
    initial begin
        exp_t e;
        forever begin
            @(posedge cell_clk); #3;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                chk("R1 pick_a", pick_a, e.pa);
                chk("R2 pick_b", pick_b, e.pb);
                chk("R3 clear_a", clear_a, e.ca);
                chk("R4 clear_b", clear_b, e.cb);
                chk("R6 ana_en", ana_en, e.en);
                chk("R7 select overlap", pick_a & pick_b, 1'b0);
                chk("R10 next pick_a", n_pa, e.nxt_pa);
                #3;
                chk("R5 ser_out", ser_out, e.so);
                chk("R9 pick_a held", pick_a, e.pa);
                chk("R9 pick_b held", pick_b, e.pb);
                chk("R9 clear_b held", clear_b, e.cb);
            end
        end
    end

    // Driver: stimulus sequence.
    initial begin
        #2;
        do_reset();
        drive_pattern(32'b1000_0000, 8);      // R1 R2 R3 R4: isolated token
        drive_pattern(32'b1000_1000_0000, 12); // tokens four periods apart
        drive_pattern(32'b1010_0000, 8);       // R7: two periods apart
        drive_pattern(32'b1100_0000, 8);       // R7: adjacent high bits
        drive_pattern(32'b1111_1100_0000, 12); // long high run
        drive_bit(1'b1);
        drive_bit(1'b0);
        wait (exp_q.size() == 0);
        #8;
        do_reset();                            // R8: reset mid-activity
        drive_pattern(32'b1000_0000, 8);
        wait (exp_q.size() == 0);
        @(posedge cell_clk); #7;
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #400000;
        if (!finished) begin
            finished = 1'b1;
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule